// File: doc/BRIEF.md
# ADC Conversion Sequencer with Pause-on-Unread

This block is the digital control around one analog-to-digital converter that has a single result register. A host reaches it over a small register bus with two addresses: a 16-bit control/status word and a read-only result word. The control word chooses how a conversion is launched: by a software start bit, or by one of three hardware trigger inputs. It also chooses whether the block stops after one result or keeps converting, and whether an interrupt is raised when a result lands.

The block drives an abstract converter with a one-cycle start pulse. It takes back a one-cycle done pulse and a 10-bit sample. A transfer engine sees the interrupt line as its request and answers with a one-cycle acknowledge. In continuous mode the block can be told to hold off. After each result it pauses until the transfer engine has taken that result, then launches the next conversion by itself, so an untransferred sample is never overwritten.

Status bits follow write-zero-to-act rules. Writing 0 to the busy bit halts conversion, and writing 0 to the result-ready bit clears it. Writing 1 to either bit leaves it unchanged. The start bit always reads back as 0.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word (address 0) reads 0x0000, the result word (address 1) reads 0x0000, and irq_o and conv_start_o are 0.
- R2: Writing address 0 with bit 9 set while idle produces a conv_start_o pulse one cycle long and sets the busy bit (bit 15). Bit 9 and bit 8 always read 0.
- R3: With bit 0 (continuous) clear, a conv_done_i pulse while busy stores conv_result_i in the result word (bits 9:0), sets the ready bit (bit 14) and clears the busy bit.
- R4: irq_o is 1 exactly when the ready bit and the enable bit (bit 13) are both 1.
- R5: A control write with bit 14 = 0 clears the ready bit, and a write with bit 14 = 1 leaves it unchanged. A write with bit 15 = 1 never sets the busy bit.
- R6: A control write with bit 15 = 0 stops conversion: the busy bit clears, no start pulse follows, and a later done pulse changes neither the result word nor the ready bit. When bit 15 = 0 and bit 9 = 1 arrive in the same write, the stop wins and no conversion starts.
- R7: Bits 11:10 choose the launch source. Value 0 means software only. Value k (1..3) means a high on hw_trig_i[k-1] while idle starts a conversion. Unselected trigger lines have no effect.
- R8: While busy, trigger pulses and software starts produce no further start pulse.
- R9: With bit 0 = 1 and bit 1 = 0, each accepted done pulse stores the sample and issues the next start pulse in the following cycle.
- R10: With bits 1:0 = 11, each accepted done pulse stores the sample, sets the pause bit (bit 12) and issues no start. While paused, software starts and triggers are ignored. An xfer_ack_i pulse clears the pause bit and issues a start pulse in the next cycle.
- R11: An xfer_ack_i pulse clears the ready bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = control/status word, 1 = result word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for bus_addr, one cycle late |
| hw_trig_i | input | 3 | Hardware launch trigger lines |
| conv_start_o | output | 1 | One-cycle start pulse to the converter |
| conv_done_i | input | 1 | One-cycle end-of-conversion pulse |
| conv_result_i | input | 10 | Converter sample, valid with conv_done_i |
| irq_o | output | 1 | Interrupt and transfer request |
| xfer_ack_i | input | 1 | Transfer engine has taken the result |

## Verification
A stuck or wrongly updated busy flag shows up within one cycle. Either a start pulse appears where none was due, or an expected one is missing, because conv_start_o is registered from the same next-state decision. A lost or stale ready or pause bit shows up on irq_o in the cycle after the edge that should have changed it, and in the control word on the following read. A result latched on the wrong done pulse shows up in the result word on the next read. A continuous or held sequence that does not advance shows up as a missing start pulse in the cycle after done or acknowledge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int RES_W   = 10;
  localparam int REG_W   = 16;
  localparam int TRIG_N  = 3;
  localparam int SEL_W   = 2;

  localparam int B_BUSY  = 15;
  localparam int B_RDY   = 14;
  localparam int B_IEN   = 13;
  localparam int B_PAUSE = 12;
  localparam int B_SELHI = 11;
  localparam int B_SELLO = 10;
  localparam int B_GO    = 9;
  localparam int B_HOLD  = 1;
  localparam int B_CONT  = 0;

  typedef struct packed {
    logic             busy;
    logic             rdy;
    logic             ien;
    logic             pause;
    logic [SEL_W-1:0] sel;
    logic             hold;
    logic             cont;
  } ctl_state_t;
endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_seq_pkg::*;
#(
  parameter int N = TRIG_N,
  parameter int W = SEL_W
) (
  input  logic [N-1:0] trig_i,
  input  logic [W-1:0] sel_i,
  output logic         hit_o
);
  logic [N-1:0] match;

  for (genvar k = 0; k < N; k++) begin : g_line
    assign match[k] = (sel_i == W'(k + 1)) && trig_i[k];
  end

  assign hit_o = |match;
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg
  import adc_seq_pkg::*;
#(
  parameter int W = RES_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] sample_i,
  output logic [W-1:0] value_o
);
  always_ff @(posedge clk) begin
    if (rst)         value_o <= '0;
    else if (load_i) value_o <= sample_i;
  end
endmodule

// File: rtl/adc_ctrl_core.sv
module adc_ctrl_core
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic             wbusy_i,
  input  logic             wrdy_i,
  input  logic             wien_i,
  input  logic [SEL_W-1:0] wsel_i,
  input  logic             wgo_i,
  input  logic             whold_i,
  input  logic             wcont_i,
  input  logic             trig_hit_i,
  input  logic             done_i,
  input  logic             ack_i,
  output ctl_state_t       st_o,
  output logic             start_o,
  output logic             load_o,
  output logic             irq_o
);
  ctl_state_t st_q, st_d;
  logic start_d;
  logic do_stop, do_launch, done_ok;

  always_comb begin
    st_d      = st_q;
    start_d   = 1'b0;
    do_stop   = wr_i && !wbusy_i;
    do_launch = ((wr_i && wgo_i) || trig_hit_i) && !st_q.busy;
    done_ok   = done_i && st_q.busy && !st_q.pause && !do_stop;

    if ((wr_i && !wrdy_i) || ack_i) st_d.rdy = 1'b0;

    if (done_ok) begin
      st_d.rdy = 1'b1;
      if (!st_q.cont)      st_d.busy  = 1'b0;
      else if (st_q.hold)  st_d.pause = 1'b1;
      else                 start_d    = 1'b1;
    end

    if (ack_i && st_q.pause) begin
      st_d.pause = 1'b0;
      start_d    = 1'b1;
    end

    if (do_launch) begin
      st_d.busy = 1'b1;
      start_d   = 1'b1;
    end

    if (wr_i) begin
      st_d.ien  = wien_i;
      st_d.sel  = wsel_i;
      st_d.hold = whold_i;
      st_d.cont = wcont_i;
    end

    if (do_stop) begin
      st_d.busy  = 1'b0;
      st_d.pause = 1'b0;
      start_d    = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= '0;
      start_o <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_o <= start_d;
      irq_o   <= st_d.rdy && st_d.ien;
    end
  end

  assign st_o   = st_q;
  assign load_o = done_ok;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [TRIG_N-1:0] hw_trig_i,
  output logic              conv_start_o,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_result_i,
  output logic              irq_o,
  input  logic              xfer_ack_i
);
  ctl_state_t       st;
  logic             trig_hit, load;
  logic [RES_W-1:0] sample_q;
  logic [REG_W-1:0] ctl_word, res_word;
  logic             wr_ctl;

  assign wr_ctl = bus_wr && !bus_addr;

  adc_trig_sel #(.N(TRIG_N), .W(SEL_W)) trig_i (
    .trig_i (hw_trig_i),
    .sel_i  (st.sel),
    .hit_o  (trig_hit)
  );

  adc_ctrl_core core_i (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (wr_ctl),
    .wbusy_i    (bus_wdata[B_BUSY]),
    .wrdy_i     (bus_wdata[B_RDY]),
    .wien_i     (bus_wdata[B_IEN]),
    .wsel_i     (bus_wdata[B_SELHI:B_SELLO]),
    .wgo_i      (bus_wdata[B_GO]),
    .whold_i    (bus_wdata[B_HOLD]),
    .wcont_i    (bus_wdata[B_CONT]),
    .trig_hit_i (trig_hit),
    .done_i     (conv_done_i),
    .ack_i      (xfer_ack_i),
    .st_o       (st),
    .start_o    (conv_start_o),
    .load_o     (load),
    .irq_o      (irq_o)
  );

  adc_result_reg #(.W(RES_W)) res_i (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load),
    .sample_i (conv_result_i),
    .value_o  (sample_q)
  );

  always_comb begin
    ctl_word          = '0;
    ctl_word[B_BUSY]  = st.busy;
    ctl_word[B_RDY]   = st.rdy;
    ctl_word[B_IEN]   = st.ien;
    ctl_word[B_PAUSE] = st.pause;
    ctl_word[B_SELHI:B_SELLO] = st.sel;
    ctl_word[B_HOLD]  = st.hold;
    ctl_word[B_CONT]  = st.cont;
    res_word          = {{(REG_W-RES_W){1'b0}}, sample_q};
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_addr ? res_word : ctl_word;
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic bus_wr,
  input logic bus_addr,
  input logic stop_bit,
  input logic busy,
  input logic rdy,
  input logic ien,
  input logic pause,
  input logic cont,
  input logic conv_start_o,
  input logic conv_done_i,
  input logic irq_o,
  input logic xfer_ack_i
);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    conv_start_o |-> busy);

  p_single_done_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && conv_done_i && !cont && !(bus_wr && !bus_addr)) |=> (!busy && rdy));

  p_irq_gate_r4: assert property (@(posedge clk) disable iff (rst)
    irq_o == (rdy && ien));

  p_stop_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_addr && !stop_bit) |=> (!busy && !conv_start_o));

  p_pause_hold_r10: assert property (@(posedge clk) disable iff (rst)
    pause |-> (busy && !conv_start_o));

  p_ack_clears_r11: assert property (@(posedge clk) disable iff (rst)
    (xfer_ack_i && !(busy && conv_done_i)) |=> !rdy);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .stop_bit     (bus_wdata[15]),
  .busy         (st.busy),
  .rdy          (st.rdy),
  .ien          (st.ien),
  .pause        (st.pause),
  .cont         (st.cont),
  .conv_start_o (conv_start_o),
  .conv_done_i  (conv_done_i),
  .irq_o        (irq_o),
  .xfer_ack_i   (xfer_ack_i)
);

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [2:0]  hw_trig_i = '0;
  logic        conv_start_o;
  logic        conv_done_i = 1'b0;
  logic [9:0]  conv_result_i = '0;
  logic        irq_o;
  logic        xfer_ack_i = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  adc_seq_ctrl dut_i (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic done(input logic [9:0] v);
    conv_done_i = 1'b1; conv_result_i = v;
    @(negedge clk);
    conv_done_i = 1'b0;
  endtask

  task automatic trig(input int k);
    hw_trig_i[k] = 1'b1;
    @(negedge clk);
    hw_trig_i = '0;
  endtask

  task automatic ack();
    xfer_ack_i = 1'b1;
    @(negedge clk);
    xfer_ack_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(1'b0, v); chk("R1 ctrl", v, 16'h0000);
    rd(1'b1, v); chk("R1 result", v, 16'h0000);
    chk("R1 irq/start", {14'b0, irq_o, conv_start_o}, 16'h0);
  endtask

  task automatic t_soft_single();
    logic [15:0] v;
    wr(1'b0, 16'hE200);
    chk("R2 start pulse", {15'b0, conv_start_o}, 16'h1);
    @(negedge clk);
    chk("R2 one cycle", {15'b0, conv_start_o}, 16'h0);
    rd(1'b0, v); chk("R2 busy, go/bit8 read 0", v, 16'hA000);
    done(10'h2A5);
    chk("R4 irq on ready", {15'b0, irq_o}, 16'h1);
    rd(1'b0, v); chk("R3 ready, idle", v, 16'h6000);
    rd(1'b1, v); chk("R3 sample", v, 16'h02A5);
  endtask

  task automatic t_flags();
    logic [15:0] v;
    wr(1'b0, 16'hE000);
    rd(1'b0, v); chk("R5 write1 keeps ready, no busy", v, 16'h6000);
    wr(1'b0, 16'hC000);
    chk("R4 irq masked", {15'b0, irq_o}, 16'h0);
    wr(1'b0, 16'hA000);
    rd(1'b0, v); chk("R5 write0 clears ready", v, 16'h2000);
    chk("R4 irq low", {15'b0, irq_o}, 16'h0);
  endtask

  task automatic t_stop();
    logic [15:0] v;
    wr(1'b0, 16'hC200);
    chk("R2 start", {15'b0, conv_start_o}, 16'h1);
    wr(1'b0, 16'h4000);
    chk("R6 no start after stop", {15'b0, conv_start_o}, 16'h0);
    done(10'h111);
    rd(1'b1, v); chk("R6 late done ignored", v, 16'h02A5);
    rd(1'b0, v); chk("R6 idle, ready clear", v, 16'h0000);
    wr(1'b0, 16'h4200);
    chk("R6 stop beats go", {15'b0, conv_start_o}, 16'h0);
    rd(1'b0, v); chk("R6 still idle", v, 16'h0000);
  endtask

  task automatic t_trig();
    logic [15:0] v;
    wr(1'b0, 16'hC000);
    trig(1);
    chk("R7 sel0 ignores hw", {15'b0, conv_start_o}, 16'h0);
    wr(1'b0, 16'hC800);
    trig(0);
    chk("R7 unselected line", {15'b0, conv_start_o}, 16'h0);
    trig(1);
    chk("R7 selected line starts", {15'b0, conv_start_o}, 16'h1);
    trig(1);
    chk("R8 trig while busy", {15'b0, conv_start_o}, 16'h0);
    wr(1'b0, 16'hCA00);
    chk("R8 go while busy", {15'b0, conv_start_o}, 16'h0);
    done(10'h3C3);
    rd(1'b1, v); chk("R7 sample", v, 16'h03C3);
    wr(1'b0, 16'h0000);
  endtask

  task automatic t_cont();
    logic [15:0] v;
    wr(1'b0, 16'hC201);
    chk("R9 first start", {15'b0, conv_start_o}, 16'h1);
    @(negedge clk);
    done(10'h055);
    chk("R9 restart after done", {15'b0, conv_start_o}, 16'h1);
    rd(1'b1, v); chk("R9 sample 1", v, 16'h0055);
    done(10'h0AA);
    chk("R9 restart again", {15'b0, conv_start_o}, 16'h1);
    rd(1'b1, v); chk("R9 overwrite", v, 16'h00AA);
    wr(1'b0, 16'h0001);
    rd(1'b0, v); chk("R6 stop continuous", v, 16'h0001);
  endtask

  task automatic t_hold();
    logic [15:0] v;
    wr(1'b0, 16'h8203);
    chk("R10 start", {15'b0, conv_start_o}, 16'h1);
    @(negedge clk);
    done(10'h123);
    chk("R10 no restart", {15'b0, conv_start_o}, 16'h0);
    rd(1'b0, v); chk("R10 paused", v, 16'hD003);
    wr(1'b0, 16'hC203);
    chk("R10 go ignored paused", {15'b0, conv_start_o}, 16'h0);
    ack();
    chk("R10 resume after ack", {15'b0, conv_start_o}, 16'h1);
    rd(1'b0, v); chk("R11 ack clears ready", v, 16'h8003);
    rd(1'b1, v); chk("R10 sample kept", v, 16'h0123);
    wr(1'b0, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_soft_single();
    t_flags();
    t_stop();
    t_trig();
    t_cont();
    t_hold();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule